// File: doc/BRIEF.md
# Timestamp Widener with Deadline Flag

This block turns samples of a narrow free-running tick counter into a monotonic 32-bit timestamp. Each accepted sample supplies only the low bits of time. The block keeps the last widened value and borrows its upper bits. If the result falls below the previous value, the narrow counter has wrapped, and the block moves the result into the next wrap period. Two source widths are supported. The 16-bit source is a down-counting interval timer, which runs at one third of 3,579,545 Hz. The 24-bit source is an up-counting power-management timer, which runs at the full 3,579,545 Hz. For a down-counting source the block takes the two's complement of the sample first, so the timestamp still rises.

Beside the timestamp, the block holds one deadline register. A load writes it with the current timestamp plus a tick offset, wrapping modulo 2^32. On every accepted sample the block raises or lowers an expired flag. The test subtracts the deadline from the new timestamp and reads the result as a signed 32-bit value, so the decision stays correct across the 32-bit wrap.

Samples enter on a valid/ready stream. The block never applies back-pressure once out of reset. `smp_ready` is low while reset is held, rises on the first clock edge after reset is released, and then stays high. A sample transfers on any rising edge where `smp_valid` and `smp_ready` are both high. The source may hold `smp_valid` low for any number of cycles.

Top module: `stamp_widen_top`

## Requirements
- R1: While reset is asserted, `stamp` is 0, `expired` is 0, the stored deadline is 0 and `smp_ready` is 0.
- R2: When `src_wide` is 0, the mask is 0xFFFF. Input bits 23..16 are ignored. The new timestamp is bits 31..16 of the previous timestamp joined with the low 16 bits of the mapped sample.
- R3: If that joined value is smaller than the previous timestamp (unsigned), the block adds mask+1 (0x10000 or 0x1000000). The step between consecutive timestamps therefore never exceeds the mask.
- R4: When `src_wide` is 1, the mask is 0xFFFFFF. The upper 8 bits come from the previous timestamp and the low 24 bits from the sample.
- R5: When `count_down` is 1, the 24-bit sample is replaced by its two's complement before masking.
- R6: Without an accepted sample, `stamp` and `expired` keep their values, whatever is on `smp_data`.
- R7: A load (`dl_load` high) stores `stamp + dl_offset` modulo 2^32 as the deadline. `stamp` here is the value before any same-cycle sample.
- R8: At a sample without a load, `expired` becomes 1 exactly when (new timestamp - deadline), read as signed 32-bit, is strictly greater than 0. Equality does not count as expired.
- R9: `expired` changes only on an accepted sample or on a load.
- R10: A load clears `expired` on the next edge. This takes priority over a sample accepted in the same cycle, although that sample still updates `stamp`.
- R11: `smp_ready` is 1 from the first edge after reset release onward, so every valid sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_data | input | 24 | Raw counter sample |
| src_wide | input | 1 | 1: 24-bit mask, 0: 16-bit mask |
| count_down | input | 1 | 1: source counts down, negate sample |
| dl_load | input | 1 | Load deadline from current timestamp plus offset |
| dl_offset | input | 32 | Tick offset for deadline load |
| stamp | output | 32 | Widened timestamp |
| expired | output | 1 | Deadline passed flag |

## Verification
Both `stamp` and `expired` are registered once. A sample or load applied before a rising edge therefore shows its effect immediately after that edge. The bench changes inputs on falling edges and compares outputs on the following falling edge, half a cycle after the capturing edge. An arithmetic model in the bench advances on the same edge, so each comparison lines up with exactly one transfer. Idle cycles are checked the same way, one falling edge later, to show that nothing has moved.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int STAMP_W = 32;
  typedef logic [STAMP_W-1:0] stamp_t;
  typedef enum logic {SRC_NARROW = 1'b0, SRC_WIDE = 1'b1} src_sel_e;
endpackage

// File: rtl/stamp_sample_map.sv
module stamp_sample_map
  import stamp_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24
) (
  input  logic [WIDE_W-1:0] raw,
  input  logic              wide_sel,
  input  logic              count_down,
  output stamp_t            low_bits,
  output stamp_t            mask
);
  localparam stamp_t MASK_NARROW = (stamp_t'(1) << NARROW_W) - stamp_t'(1);
  localparam stamp_t MASK_WIDE   = (stamp_t'(1) << WIDE_W) - stamp_t'(1);
  localparam int     PAD_W       = STAMP_W - WIDE_W;

  logic [WIDE_W-1:0] oriented;
  src_sel_e          sel;

  always_comb begin
    sel      = src_sel_e'(wide_sel);
    oriented = count_down ? (~raw + {{(WIDE_W-1){1'b0}}, 1'b1}) : raw;
    mask     = (sel == SRC_WIDE) ? MASK_WIDE : MASK_NARROW;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign low_bits = {{PAD_W{1'b0}}, oriented} & mask;
    end else begin : g_nopad
      assign low_bits = stamp_t'(oriented) & mask;
    end
  endgenerate
endmodule

// File: rtl/stamp_extend.sv
module stamp_extend
  import stamp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  stamp_t low_bits,
  input  stamp_t mask,
  output stamp_t stamp_q,
  output stamp_t stamp_next
);
  stamp_t joined;

  always_comb begin
    joined = (stamp_q & ~mask) | low_bits;
    if (joined < stamp_q) stamp_next = joined + mask + stamp_t'(1);
    else                  stamp_next = joined;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    stamp_q <= '0;
    else if (take) stamp_q <= stamp_next;
  end

  assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((stamp_q & $past(mask)) == $past(low_bits)));

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((stamp_q - $past(stamp_q)) <= $past(mask)));

  assert_hold_stamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(stamp_q));
endmodule

// File: rtl/stamp_deadline.sv
module stamp_deadline
  import stamp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  logic   load,
  input  stamp_t offset,
  input  stamp_t stamp_now,
  input  stamp_t stamp_next,
  output logic   expired
);
  stamp_t dl_q;
  stamp_t gap;
  logic   past_due;

  always_comb begin
    gap      = stamp_next - dl_q;
    past_due = !gap[STAMP_W-1] && (gap != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_q    <= '0;
      expired <= 1'b0;
    end else if (load) begin
      dl_q    <= stamp_now + offset;
      expired <= 1'b0;
    end else if (take) begin
      expired <= past_due;
    end
  end

  assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired);

  assert_hold_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !load) |=> $stable(expired));
endmodule

// File: rtl/stamp_widen_top.sv
module stamp_widen_top
  import stamp_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [WIDE_W-1:0] smp_data,
  input  logic              src_wide,
  input  logic              count_down,
  input  logic              dl_load,
  input  logic [31:0]       dl_offset,
  output logic [31:0]       stamp,
  output logic              expired
);
  logic   ready_q;
  logic   take;
  stamp_t low_bits;
  stamp_t mask;
  stamp_t stamp_q;
  stamp_t stamp_next;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign smp_ready = ready_q;
  assign take      = smp_valid & ready_q;
  assign stamp     = stamp_q;

  stamp_sample_map #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) map_i (
    .raw(smp_data), .wide_sel(src_wide), .count_down(count_down),
    .low_bits(low_bits), .mask(mask));

  stamp_extend ext_i (
    .clk(clk), .rst_n(rst_n), .take(take), .low_bits(low_bits), .mask(mask),
    .stamp_q(stamp_q), .stamp_next(stamp_next));

  stamp_deadline dl_i (
    .clk(clk), .rst_n(rst_n), .take(take), .load(dl_load), .offset(dl_offset),
    .stamp_now(stamp_q), .stamp_next(stamp_next), .expired(expired));

  assert_ready_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> smp_ready);
endmodule

// File: tb/stamp_widen_top_tb.sv
`timescale 1ns/1ps
module stamp_widen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [23:0] smp_data = '0;
  logic        src_wide = 1'b0;
  logic        count_down = 1'b0;
  logic        dl_load = 1'b0;
  logic [31:0] dl_offset = '0;
  logic [31:0] stamp;
  logic        expired;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] m_last = '0;
  logic [31:0] m_dl   = '0;
  logic        m_exp  = 1'b0;

  always #2.5 clk = ~clk;

  stamp_widen_top dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .src_wide(src_wide), .count_down(count_down),
    .dl_load(dl_load), .dl_offset(dl_offset), .stamp(stamp), .expired(expired));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  function automatic logic [31:0] widen(input logic [31:0] last, input logic [23:0] s,
                                         input bit wide, input bit down);
    logic [23:0] v;
    logic [31:0] m, j;
    v = down ? 24'(-s) : s;
    m = wide ? 32'h00FF_FFFF : 32'h0000_FFFF;
    j = (last & ~m) | ({8'h00, v} & m);
    if (j < last) j = j + m + 32'd1;
    return j;
  endfunction

  task automatic sample(input logic [23:0] s, input bit wide, input bit down,
                        input bit ld, input logic [31:0] off, input string tag);
    logic [31:0] nxt;
    @(negedge clk);
    smp_data = s; src_wide = wide; count_down = down;
    smp_valid = 1'b1; dl_load = ld; dl_offset = off;
    @(negedge clk);
    smp_valid = 1'b0; dl_load = 1'b0;
    nxt = widen(m_last, s, wide, down);
    if (ld) begin
      m_dl  = m_last + off;
      m_exp = 1'b0;
    end else begin
      m_exp = $signed(nxt - m_dl) > 0;
    end
    m_last = nxt;
    check(stamp == m_last, tag, stamp, m_last);
    check(expired == m_exp, ld ? "R10" : "R8", {31'b0, expired}, {31'b0, m_exp});
  endtask

  task automatic load_only(input logic [31:0] off);
    @(negedge clk);
    dl_load = 1'b1; dl_offset = off;
    @(negedge clk);
    dl_load = 1'b0;
    m_dl = m_last + off;
    m_exp = 1'b0;
    check(expired == 1'b0, "R10", {31'b0, expired}, 32'd0);
    check(stamp == m_last, "R7 stamp", stamp, m_last);
  endtask

  // step the timestamp by k ticks using the 16-bit up-count source
  task automatic step_by(input logic [15:0] k);
    logic [15:0] lo;
    lo = m_last[15:0] + k;
    sample({8'h5A, lo}, 1'b0, 1'b0, 1'b0, 32'd0, "R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [23:0] c;
    logic [31:0] offs [7];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(stamp == 32'd0, "R1", stamp, 32'd0);
    check(expired == 1'b0, "R1", {31'b0, expired}, 32'd0);
    check(smp_ready == 1'b0, "R1", {31'b0, smp_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_ready == 1'b1, "R11", {31'b0, smp_ready}, 32'd1);

    // R2/R3: 16-bit up-count sweep with junk above the mask
    c = '0;
    for (int i = 0; i < 200; i++) begin
      c = c + 24'h001357;
      sample({8'(i * 37), c[15:0]}, 1'b0, 1'b0, 1'b0, 32'd0, "R2 R3");
    end
    // R5: 16-bit down-count sweep
    c = 24'h00FFFF;
    for (int i = 0; i < 200; i++) begin
      c = c - 24'h000FED;
      sample({8'(i * 11), c[15:0]}, 1'b0, 1'b1, 1'b0, 32'd0, "R5");
    end
    // R4: 24-bit up-count sweep
    c = m_last[23:0];
    for (int i = 0; i < 300; i++) begin
      c = c + 24'h2A5A5B;
      sample(c, 1'b1, 1'b0, 1'b0, 32'd0, "R4 R3");
    end
    // R5 with 24-bit mask
    for (int i = 0; i < 100; i++) begin
      c = c - 24'h13579B;
      sample(c, 1'b1, 1'b1, 1'b0, 32'd0, "R5 R4");
    end

    // R6: idle cycles with changing data
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      smp_data = 24'(i * 24'h0A0B0C);
      src_wide = i[0];
      count_down = i[1];
      @(negedge clk);
      check(stamp == m_last, "R6", stamp, m_last);
      check(expired == m_exp, "R6", {31'b0, expired}, {31'b0, m_exp});
    end

    // R7/R8: deadline edges
    offs = '{32'd0, 32'd1, 32'd5, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF};
    foreach (offs[i]) begin
      load_only(offs[i]);
      step_by(16'd0);
      step_by(16'd1);
      step_by(16'd3);
      step_by(16'd2);
      step_by(16'hFFF0);
    end

    // R10: load together with a sample
    sample({8'h00, m_last[15:0] + 16'd9}, 1'b0, 1'b0, 1'b1, 32'd4, "R10 R7");
    step_by(16'd4);
    step_by(16'd1);
    step_by(16'd0);
    sample({8'h00, m_last[15:0] + 16'd2}, 1'b0, 1'b0, 1'b1, 32'd0, "R10 R7");
    // R9: after a load, flag held until next sample
    @(negedge clk);
    check(expired == 1'b0, "R9", {31'b0, expired}, 32'd0);
    step_by(16'd1);

    report();
  end
endmodule